// File: doc/BRIEF.md
# Slot-Table DMA Service Scheduler

This block decides, cycle by cycle, which DMA channel and direction is offered a service slot. Software fills a table of one-byte entries. Each entry names a channel and says whether the slot serves transmit or receive. Software then writes a control word that turns the scheduler on and gives the index of the last valid entry.

While the scheduler runs, it visits one entry per clock. It starts at entry 0, goes up to the last index and then wraps back to 0. For the entry being visited, a grant is raised only if that channel's request bit for the named direction is set. If the bit is clear, the slot passes with no grant.

A programming sequence follows a strict order. First, clear the control word to stop the scheduler. Then write the table. Only after every table word is written, set the enable bit. The block enforces this order: a table write that arrives while the scheduler is enabled is dropped. Both the control word and the table can be read back through the same register port.

Top module: `dma_slot_sched`

## Requirements
- R1: After reset the control word reads 0 and no grant is issued.
- R2: The control word sits at offset 0x000. Bit 31 is the enable. Bits [IDX_W-1:0] hold the last valid entry index. All other bits read 0. An unmapped offset reads 0.
- R3: Table word w sits at offset 0x800 + 4*w, for w from 0 to TBL_WORDS-1. While the scheduler is stopped, a write stores the word and a read returns the last value stored.
- R4: A write to a table word while the enable bit is set is dropped, and the table word keeps its old value.
- R5: Entry 4*w+k is byte lane k of table word w, which is bits [8k+7:8k]. Within the byte, bits [4:0] give the channel and bit 7 set means receive. Bits 6:5 are ignored.
- R6: The enable takes effect on the clock edge that stores it. From the next clock edge, each edge registers one entry onto the grant outputs, in the order 0, 1, ..., last, 0, ... .
- R7: For the entry visited, gnt_valid is 1 exactly when the matching request bit was set: rx_req[chan] if bit 7 of the entry is set, tx_req[chan] otherwise. When gnt_valid is 1, gnt_chan and gnt_rx carry that entry's fields.
- R8: While the scheduler is disabled no grant is issued, and re-enabling it restarts the sequence at entry 0.
- R9: Whenever gnt_valid is 0, gnt_chan and gnt_rx are 0.
- R10: With a last index of 0, the same entry 0 is visited on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| tx_req | input | NUM_CH | Per-channel transmit service requests |
| rx_req | input | NUM_CH | Per-channel receive service requests |
| gnt_valid | output | 1 | Grant strobe for the slot just visited |
| gnt_chan | output | 5 | Channel number of the granted entry |
| gnt_rx | output | 1 | Granted entry is for the receive direction |

## Verification
Several properties are checked on every cycle:
- A grant always points back to a request bit that was set one cycle earlier.
- The grant fields stay at zero between grants.
- A disabled scheduler produces no grant.
- The slot pointer only leaves 0 while enabled and steps by one below the last index.
- A blocked table write leaves the storage unchanged.

The bench's scenarios cover what these per-cycle properties cannot show. They sweep the last index (63, 59, 5 and 0) and check the complete visiting order against a table computed in the bench. They decode every byte lane, hold several request masks, and check readback of the control word and table. They also show that the sequence restarts at entry 0 after a disable.

// File: rtl/dma_slot_sched_pkg.sv
package dma_slot_sched_pkg;
  localparam int CH_W = 5;
  localparam int CH_SPACE = 1 << CH_W;
  localparam int ENT_RX_BIT = 7;

  function automatic logic [CH_W-1:0] entry_chan(input logic [7:0] ent);
    return ent[CH_W-1:0];
  endfunction

  function automatic logic entry_is_rx(input logic [7:0] ent);
    return ent[ENT_RX_BIT];
  endfunction

  function automatic logic [7:0] lane_of(input logic [31:0] word, input logic [1:0] lane);
    return word[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] ctrl_pack(input logic en, input logic [23:0] last_ext);
    return {en, 7'd0, last_ext};
  endfunction
endpackage

// File: rtl/sched_regs.sv
module sched_regs
  import dma_slot_sched_pkg::*;
#(
  parameter int TBL_WORDS = 16,
  parameter int IDX_W = 6,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    en,
  output logic [IDX_W-1:0]        last,
  output logic [TBL_WORDS*32-1:0] tbl_flat
);
  localparam int TW_W = $clog2(TBL_WORDS);
  localparam logic [ADDR_W-1:0] TBL_BASE = ADDR_W'(12'h800);

  logic             en_q;
  logic [IDX_W-1:0] last_q;
  logic [31:0]      tbl_q [TBL_WORDS];

  logic            ctrl_sel;
  logic            tbl_sel;
  logic [TW_W-1:0] widx;
  logic            tbl_wr_ok;
  logic            tbl_wr_blocked;

  assign ctrl_sel = (addr == '0);
  assign tbl_sel = (addr[ADDR_W-1:2+TW_W] == TBL_BASE[ADDR_W-1:2+TW_W]) && (addr[1:0] == 2'b00);
  assign widx = addr[2+TW_W-1:2];
  assign tbl_wr_ok = wr_en && tbl_sel && !en_q;
  assign tbl_wr_blocked = wr_en && tbl_sel && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      last_q <= '0;
    end else if (wr_en && ctrl_sel) begin
      en_q   <= wdata[31];
      last_q <= wdata[IDX_W-1:0];
    end
  end

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) tbl_q[w] <= '0;
      else if (tbl_wr_ok && (widx == TW_W'(w))) tbl_q[w] <= wdata;
    end
    assign tbl_flat[w*32 +: 32] = tbl_q[w];
  end

  always_comb begin
    if (ctrl_sel) rdata = ctrl_pack(en_q, 24'(last_q));
    else if (tbl_sel) rdata = tbl_q[widx];
    else rdata = '0;
  end

  assign en = en_q;
  assign last = last_q;

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_blocked |=> $stable(tbl_flat));
  assert_reset_ctrl_R1: assert property (@(posedge clk)
    !rst_n |=> (!en_q && last_q == '0));
endmodule

// File: rtl/sched_seq.sv
module sched_seq #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] slot,
  output logic             wrap
);
  logic [IDX_W-1:0] slot_q;

  function automatic logic [IDX_W-1:0] next_slot(input logic run, input logic [IDX_W-1:0] cur,
                                                 input logic [IDX_W-1:0] lim);
    if (!run || cur >= lim) return '0;
    return cur + 1'b1;
  endfunction

  assign wrap = en && (slot_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else slot_q <= next_slot(en, slot_q, last);
  end

  assign slot = slot_q;

  assert_idle_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != '0) |-> $past(en));
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap && $stable(last)) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/sched_grant.sv
module sched_grant
  import dma_slot_sched_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int TBL_WORDS = 16,
  parameter int IDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [IDX_W-1:0]        slot,
  input  logic [TBL_WORDS*32-1:0] tbl_flat,
  input  logic [NUM_CH-1:0]       tx_req,
  input  logic [NUM_CH-1:0]       rx_req,
  output logic                    gnt_valid,
  output logic [CH_W-1:0]         gnt_chan,
  output logic                    gnt_rx
);
  logic [CH_SPACE-1:0] tx_pad;
  logic [CH_SPACE-1:0] rx_pad;
  logic [31:0]         cur_word;
  logic [7:0]          cur_entry;
  logic [CH_W-1:0]     cur_chan;
  logic                cur_rx;
  logic                slot_hit;

  assign tx_pad = CH_SPACE'(tx_req);
  assign rx_pad = CH_SPACE'(rx_req);
  assign cur_word = tbl_flat[slot[IDX_W-1:2]*32 +: 32];
  assign cur_entry = lane_of(cur_word, slot[1:0]);
  assign cur_chan = entry_chan(cur_entry);
  assign cur_rx = entry_is_rx(cur_entry);
  assign slot_hit = en && (cur_rx ? rx_pad[cur_chan] : tx_pad[cur_chan]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
      gnt_rx    <= 1'b0;
    end else begin
      gnt_valid <= slot_hit;
      gnt_chan  <= slot_hit ? cur_chan : '0;
      gnt_rx    <= slot_hit && cur_rx;
    end
  end

  assert_gnt_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (((gnt_rx ? $past(rx_pad) : $past(tx_pad)) >> gnt_chan) & 1) != 0);
  assert_no_gnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gnt_valid);
  assert_quiet_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt_chan == '0 && !gnt_rx));
endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
  import dma_slot_sched_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int TBL_WORDS = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NUM_CH-1:0] tx_req,
  input  logic [NUM_CH-1:0] rx_req,
  output logic              gnt_valid,
  output logic [4:0]        gnt_chan,
  output logic              gnt_rx
);
  localparam int ENTRIES = TBL_WORDS * 4;
  localparam int IDX_W = $clog2(ENTRIES);

  logic                    run_en;
  logic [IDX_W-1:0]        last_idx;
  logic [TBL_WORDS*32-1:0] tbl_flat;
  logic [IDX_W-1:0]        slot;
  logic                    slot_wrap;

  sched_regs #(.TBL_WORDS(TBL_WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(run_en), .last(last_idx), .tbl_flat(tbl_flat)
  );

  sched_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(run_en), .last(last_idx), .slot(slot), .wrap(slot_wrap)
  );

  sched_grant #(.NUM_CH(NUM_CH), .TBL_WORDS(TBL_WORDS), .IDX_W(IDX_W)) u_gnt (
    .clk(clk), .rst_n(rst_n), .en(run_en), .slot(slot), .tbl_flat(tbl_flat),
    .tx_req(tx_req), .rx_req(rx_req), .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_rx(gnt_rx)
  );

  assert_wrap_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wrap && $stable(last_idx)) |=> (slot == '0));
endmodule

// File: tb/sim_dma_slot_sched.sv
module sim_dma_slot_sched;
  localparam int CLK_NS = 10;
  localparam int NCH = 32;
  localparam int WORDS = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] tx_req = '0;
  logic [NCH-1:0] rx_req = '0;
  logic        gnt_valid;
  logic [4:0]  gnt_chan;
  logic        gnt_rx;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_slot_sched #(.NUM_CH(NCH), .TBL_WORDS(WORDS), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_req(tx_req), .rx_req(rx_req),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_rx(gnt_rx)
  );

  function automatic logic [7:0] ent_byte(input int e);
    return 8'((((e >> 5) & 1) << 7) | (e & 31));
  endfunction

  function automatic logic [31:0] word_val(input int w);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = ent_byte(4*w + k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic check_slot(input int e, input string req);
    logic [7:0] b;
    logic [4:0] ch;
    logic rx, hit;
    b = ent_byte(e);
    ch = b[4:0];
    rx = b[7];
    hit = rx ? rx_req[ch] : tx_req[ch];
    chk(gnt_valid == hit && gnt_chan == (hit ? ch : 5'd0) && gnt_rx == (hit && rx), req,
        {25'd0, gnt_valid, gnt_rx, gnt_chan}, {25'd0, hit, hit && rx, hit ? ch : 5'd0});
  endtask

  task automatic run_check(input int last, input int cycles, input string req);
    wr(12'h000, 32'h8000_0000 | 32'(last));
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check_slot(k % (last + 1), req);
    end
    wr(12'h000, 32'h0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(12'h000, d);
    chk(d == 0, "R1 ctrl", d, 0);
    chk(!gnt_valid, "R1 gnt", {31'd0, gnt_valid}, 0);
    // R2: unmapped offsets
    rd(12'h004, d);
    chk(d == 0, "R2 unmapped", d, 0);
    rd(12'h840, d);
    chk(d == 0, "R2 past table", d, 0);
    // R3: table write and readback
    for (int w = 0; w < WORDS; w++) wr(12'h800 + 12'(4*w), word_val(w));
    for (int w = 0; w < WORDS; w++) begin
      rd(12'h800 + 12'(4*w), d);
      chk(d == word_val(w), "R3 table", d, word_val(w));
    end
    // R2: ctrl readback, disabled so no effect on sequence
    wr(12'h000, 32'h7FFF_FFFB);
    rd(12'h000, d);
    chk(d == 32'h0000_003B, "R2 ctrl mask", d, 32'h0000_003B);
    wr(12'h000, 32'h0);
    // R6 R5 R10: order sweep with all requests set
    tx_req = '1; rx_req = '1;
    run_check(63, 130, "R6 last63");
    rd(12'h000, d);
    chk(d == 0, "R2 ctrl cleared", d, 0);
    run_check(59, 125, "R6 last59");
    run_check(5, 20, "R5 last5");
    run_check(0, 6, "R10 last0");
    // R7: request masks
    tx_req = 32'hA5A5_0F0F; rx_req = 32'h5A5A_F0F0;
    run_check(63, 64, "R7 mask1");
    tx_req = 32'h0000_0001; rx_req = 32'h8000_0000;
    run_check(63, 64, "R7 mask2");
    tx_req = '0; rx_req = '0;
    run_check(63, 64, "R9 nomask");
    // R4: write while running is dropped
    tx_req = '1; rx_req = '1;
    wr(12'h000, 32'h8000_003F);
    wr(12'h80C, 32'hFFFF_FFFF);
    rd(12'h80C, d);
    chk(d == word_val(3), "R4 frozen", d, word_val(3));
    // R8: disable stops grants
    wr(12'h000, 32'h0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!gnt_valid && gnt_chan == 0 && !gnt_rx, "R8 idle", {30'd0, gnt_valid, gnt_rx}, 0);
    end
    // R8: restart from entry 0
    run_check(63, 10, "R8 restart");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule